// File: doc/BRIEF.md
# Output Fault Retry Supervisor

This block watches one regulated supply output through two digital comparator flags. One flag says that the current clamp is active. The other says that current is flowing back into the output stage above a threshold. The block decides when the output stage may be enabled, and it reports an overload bit and a reverse-current bit to the surrounding status logic.

A select input chooses the protection mode. In static mode a clamp event is only reported, and the overload bit follows the clamp flag. In dynamic mode a clamp that persists is handled like a reverse-current fault. Any fault must be present on every sample of a qualification window before it counts. A qualified fault turns the output off for a long, fixed interval. The output is then re-enabled. If the fault is still there, the same on/off cycle repeats for as long as it lasts. Once the output runs fault-free for one window, the fault bits clear.

Both time bases are parameters counted in clock cycles. While the soft-start done input is low, everything is held in its idle state, so both bits read low when soft-start ends.

Top module: `out_fault_retry`

## Requirements
- R1: While rst_n is low, or while ss_done_i is low, out_en_o is 1 and ovl_flag_o and rev_flag_o are 0. This holds whatever the fault inputs do.
- R2: In static mode (static_sel_i = 1), ovl_flag_o equals the value clamp_hit_i had at the previous clock edge, and a clamp never lowers out_en_o.
- R3: A fault (bkcur_hit_i, or clamp_hit_i with static_sel_i = 0) that drops before QUAL_CYC+1 consecutive sampled cycles leaves out_en_o at 1. The next fault run counts from zero.
- R4: When a fault is sampled high on QUAL_CYC+1 consecutive edges while the output is on, out_en_o is 0 after the last of those edges. At that edge rev_flag_o is set if bkcur_hit_i is high.
- R5: Once out_en_o falls, it stays 0 for exactly OFF_CYC cycles and then returns to 1 without any input action.
- R6: If the fault stays present, out_en_o repeats QUAL_CYC+1 cycles high and OFF_CYC cycles low for as long as it lasts.
- R7: After the output is back on, the fault flags that were set by tripping clear at the QUAL_CYC-th consecutive fault-free sampled edge.
- R8: In dynamic mode (static_sel_i = 0), a qualified clamp trips the output and sets ovl_flag_o, and leaves rev_flag_o at 0 when bkcur_hit_i is low.
- R9: In static mode a persistent clamp never trips the output. A persistent reverse current still trips it.
- R10: Dropping ss_done_i while the output is off re-enables the output and clears both flags after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clamp_hit_i | input | 1 | Current clamp active (synchronous) |
| bkcur_hit_i | input | 1 | Reverse current above threshold (synchronous) |
| static_sel_i | input | 1 | 1 = static protection, 0 = dynamic protection |
| ss_done_i | input | 1 | Soft-start complete; low holds the block idle |
| out_en_o | output | 1 | Output stage enable |
| ovl_flag_o | output | 1 | Overload status bit |
| rev_flag_o | output | 1 | Reverse-current status bit |

## Verification
The bench builds the block with QUAL_CYC = 4 and OFF_CYC = 10. With these values a full trip, the off interval, several retry cycles and the clean-window clear all fit within a few dozen cycles, and every boundary can be hit on its exact edge. Fault runs of exactly QUAL_CYC and QUAL_CYC+1 samples separate a near miss from a trip. A behavioural model with integer counters is compared against all three outputs on every cycle, including a soft-start drop in the middle of an off interval.

// File: rtl/out_fault_retry.sv
module out_fault_retry #(
  parameter int QUAL_CYC = 2000,
  parameter int OFF_CYC  = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clamp_hit_i,
  input  logic bkcur_hit_i,
  input  logic static_sel_i,
  input  logic ss_done_i,
  output logic out_en_o,
  output logic ovl_flag_o,
  output logic rev_flag_o
);
  localparam int QW = $clog2(QUAL_CYC + 1);
  localparam int OW = $clog2(OFF_CYC + 1);

  logic          on_q;
  logic [QW-1:0] run_q, clean_q;
  logic [OW-1:0] off_q;
  logic          ovl_stat_q, ovl_dyn_q, rev_q;

  wire dyn_clamp  = ~static_sel_i & clamp_hit_i;
  wire fault      = bkcur_hit_i | dyn_clamp;
  wire trip       = on_q & fault & (run_q == QW'(QUAL_CYC));
  wire off_done   = (off_q == OW'(OFF_CYC - 1));
  wire clean_done = ~fault & (clean_q == QW'(QUAL_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b1; run_q <= '0; clean_q <= '0; off_q <= '0;
      ovl_stat_q <= 1'b0; ovl_dyn_q <= 1'b0; rev_q <= 1'b0;
    end else if (!ss_done_i) begin
      on_q <= 1'b1; run_q <= '0; clean_q <= '0; off_q <= '0;
      ovl_stat_q <= 1'b0; ovl_dyn_q <= 1'b0; rev_q <= 1'b0;
    end else begin
      ovl_stat_q <= static_sel_i & clamp_hit_i;
      if (on_q) begin
        if (trip) begin
          on_q      <= 1'b0;
          off_q     <= '0;
          run_q     <= '0;
          clean_q   <= '0;
          rev_q     <= rev_q | bkcur_hit_i;
          ovl_dyn_q <= ovl_dyn_q | dyn_clamp;
        end else if (fault) begin
          run_q   <= run_q + 1'b1;
          clean_q <= '0;
        end else begin
          run_q <= '0;
          if (clean_done) begin
            rev_q     <= 1'b0;
            ovl_dyn_q <= 1'b0;
          end else begin
            clean_q <= clean_q + 1'b1;
          end
        end
      end else begin
        run_q   <= '0;
        clean_q <= '0;
        if (off_done) begin
          on_q  <= 1'b1;
          off_q <= '0;
        end else begin
          off_q <= off_q + 1'b1;
        end
      end
    end
  end

  assign out_en_o   = on_q;
  assign ovl_flag_o = ovl_stat_q | ovl_dyn_q;
  assign rev_flag_o = rev_q;
endmodule

// File: rtl/out_fault_retry_chk.sv
module out_fault_retry_chk #(
  parameter int QUAL_CYC = 2000,
  parameter int OFF_CYC  = 100000
) (
  input logic clk,
  input logic rst_n,
  input logic clamp_hit_i,
  input logic bkcur_hit_i,
  input logic static_sel_i,
  input logic ss_done_i,
  input logic out_en_o,
  input logic ovl_flag_o,
  input logic rev_flag_o
);
  logic [31:0] lowcnt, hicnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt <= '0;
      hicnt  <= '0;
    end else begin
      lowcnt <= out_en_o ? 32'd0 : lowcnt + 32'd1;
      if (!out_en_o)          hicnt <= '0;
      else if (hicnt != '1)   hicnt <= hicnt + 32'd1;
    end
  end

  p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done_i |=> (out_en_o && !ovl_flag_o && !rev_flag_o));

  p_static_report_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_done_i && static_sel_i && clamp_hit_i) |=> ovl_flag_o);

  p_trip_flagged_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_en_o) |-> (ovl_flag_o || rev_flag_o));

  p_off_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_en_o) && $past(ss_done_i)) |-> (lowcnt == OFF_CYC));

  p_min_on_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_en_o) |-> (hicnt >= QUAL_CYC + 1));
endmodule

bind out_fault_retry out_fault_retry_chk #(.QUAL_CYC(QUAL_CYC), .OFF_CYC(OFF_CYC)) u_chk (.*);

// File: tb/tb_out_fault_retry.sv
module tb_out_fault_retry;
  localparam int CLK_PERIOD = 10;
  localparam int Q   = 4;
  localparam int OFF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clamp = 1'b0, bk = 1'b0, stat = 1'b0, ss = 1'b0;
  logic out_en, ovl, rev;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  string phase = "R1";

  out_fault_retry #(.QUAL_CYC(Q), .OFF_CYC(OFF)) dut (
    .clk(clk), .rst_n(rst_n), .clamp_hit_i(clamp), .bkcur_hit_i(bk),
    .static_sel_i(stat), .ss_done_i(ss),
    .out_en_o(out_en), .ovl_flag_o(ovl), .rev_flag_o(rev));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  bit m_on = 1'b1, m_stat_ovl = 1'b0, m_dyn_ovl = 1'b0, m_rev = 1'b0;
  int m_run = 0, m_clean = 0, m_off_left = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !ss) begin
      m_on = 1'b1; m_stat_ovl = 1'b0; m_dyn_ovl = 1'b0; m_rev = 1'b0;
      m_run = 0; m_clean = 0; m_off_left = 0;
    end else begin
      bit f;
      f = bk || (!stat && clamp);
      m_stat_ovl = stat && clamp;
      if (m_on) begin
        if (f) begin
          m_clean = 0;
          if (m_run == Q) begin
            m_on = 1'b0; m_off_left = OFF; m_run = 0;
            if (bk) m_rev = 1'b1;
            if (!stat && clamp) m_dyn_ovl = 1'b1;
          end else m_run++;
        end else begin
          m_run = 0;
          if (m_clean == Q - 1) begin m_rev = 1'b0; m_dyn_ovl = 1'b0; end
          else m_clean++;
        end
      end else begin
        m_run = 0; m_clean = 0;
        m_off_left--;
        if (m_off_left == 0) m_on = 1'b1;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(out_en, m_on, "model out_en");
    chk(ovl, m_stat_ovl | m_dyn_ovl, "model ovl");
    chk(rev, m_rev, "model rev");
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    step(2);
    phase = "R1";
    chk(out_en, 1'b1, "reset out_en");
    chk(ovl, 1'b0, "reset ovl");
    chk(rev, 1'b0, "reset rev");
    rst_n = 1'b1;
    bk = 1'b1; clamp = 1'b1;
    step(3 * Q);
    chk(out_en, 1'b1, "R1 soft-start out_en");
    chk(rev, 1'b0, "R1 soft-start rev");
    bk = 1'b0; clamp = 1'b0;
    step(1);
    ss = 1'b1;
    step(2);

    // R2 / R9: static clamp only reports
    phase = "R2"; stat = 1'b1; clamp = 1'b1;
    step(1);
    chk(ovl, 1'b1, "R2 ovl follows clamp");
    phase = "R9";
    step(3 * Q);
    chk(out_en, 1'b1, "R9 static clamp no trip");
    phase = "R2"; clamp = 1'b0;
    step(1);
    chk(ovl, 1'b0, "R2 ovl clears with clamp");

    // R3: near miss, counter restarts
    phase = "R3"; stat = 1'b0;
    bk = 1'b1; step(Q); bk = 1'b0; step(1);
    bk = 1'b1; step(Q); bk = 1'b0; step(1);
    chk(out_en, 1'b1, "R3 short runs no trip");
    chk(rev, 1'b0, "R3 rev stays low");
    step(Q);

    // R4: trip
    phase = "R4"; bk = 1'b1;
    step(Q);
    chk(out_en, 1'b1, "R4 still on after Q samples");
    step(1);
    chk(out_en, 1'b0, "R4 off after Q+1 samples");
    chk(rev, 1'b1, "R4 rev set");

    // R5: off interval length
    phase = "R5";
    for (int i = 1; i < OFF; i++) begin
      step(1);
      chk(out_en, 1'b0, "R5 still off");
    end
    step(1);
    chk(out_en, 1'b1, "R5 back on after OFF_CYC");

    // R6: retry repeats while fault persists
    phase = "R6";
    step(Q);
    chk(out_en, 1'b1, "R6 on window");
    step(1);
    chk(out_en, 1'b0, "R6 second trip");
    bk = 1'b0;
    step(OFF);
    chk(out_en, 1'b1, "R6 recovery on");

    // R7: clean window clears flags
    phase = "R7";
    step(Q - 1);
    chk(rev, 1'b1, "R7 rev held before window end");
    step(1);
    chk(rev, 1'b0, "R7 rev cleared after clean window");

    // R8: dynamic clamp trips
    phase = "R8"; clamp = 1'b1;
    step(Q + 1);
    chk(out_en, 1'b0, "R8 dynamic clamp trips");
    chk(ovl, 1'b1, "R8 ovl set");
    chk(rev, 1'b0, "R8 rev unaffected");
    clamp = 1'b0;
    step(OFF + Q + 2);
    chk(ovl, 1'b0, "R8 ovl clears after recovery");
    chk(out_en, 1'b1, "R8 output restored");

    // R9: static reverse current still trips; R10: soft-start drop
    phase = "R9"; stat = 1'b1; bk = 1'b1;
    step(Q + 1);
    chk(out_en, 1'b0, "R9 static reverse trip");
    chk(rev, 1'b1, "R9 rev set");
    step(3);
    phase = "R10"; ss = 1'b0;
    step(1);
    chk(out_en, 1'b1, "R10 forced on");
    chk(rev, 1'b0, "R10 rev cleared");
    chk(ovl, 1'b0, "R10 ovl cleared");
    bk = 1'b0; ss = 1'b1;
    step(4);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule